// File: doc/BRIEF.md
# Overflow/Match Reload PWM Timer

This block generates a pulse-width-modulated output from an up-counting timer. The counter runs toward all-ones. On the wrap from all-ones it reloads from a period register, called load here, and the output enters its active phase. When the counter later equals a match register, the output returns to its inactive phase. The period therefore follows from how far load sits below the top of the count range. The active width follows from how far match sits above load.

Software-side logic drives the timer through a small write port. Through this port it can set load and match directly, or write a control word that holds the run and polarity-inversion bits. A second front end accepts a requested period and duty in clock cycles and converts them into load and match. The front end clamps an unusable duty and rejects a period that is too short. Starting the timer primes the counter two steps below the wrap, so the first active edge follows almost at once. The running and inversion bits are visible as status outputs.

Top module: `ovf_match_pwm`

## Requirements
- R1: After a synchronous reset, the running bit, the inversion bit, the error flag and the output are all low.
- R2: While running, the counter increments each cycle. When it is at all-ones it reloads with load and the active phase begins. The active phase ends on the cycle after the counter equals match. The output is therefore active for match−load+1 cycles in a period of (all-ones − load + 1) cycles.
- R3: Writing the control word (wr_sel = 2) with bit 0 set while stopped starts the timer with the counter at all-ones minus one. The output becomes active at the second clock edge after the edge that captured the write.
- R4: A control write with bit 0 clear stops the timer at the capturing edge, without finishing the period. The counter holds its value and the output goes inactive.
- R5: Control bit 1 inverts the output. While stopped, the output holds its inactive level: low when not inverted, high when inverted.
- R6: A control write that keeps bit 0 set but changes bit 1 while running applies the new polarity. It also restarts the timer from all-ones minus one, with the output inactive.
- R7: A conversion request (cfg_req) with a period below 2 sets cfg_err and leaves load and match unchanged.
- R8: The front end raises a duty of 0 to 1 and lowers a duty at or above the period to period−1.
- R9: An accepted conversion sets load to 2^32 − period and match to load + duty − 1, and clears cfg_err. The result is a period of `period` cycles and an active time of `duty` cycles.
- R10: Direct writes of load (wr_sel = 0) and match (wr_sel = 1) take effect at the capturing edge, even while the timer runs.
- R11: stat_run and stat_inv follow control bits 0 and 1. A write with wr_sel = 3 has no effect. When cfg_req and a load/match write coincide, the conversion wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 load, 1 match, 2 control, 3 none |
| wr_data | input | 32 | Write data; control uses bit 0 run, bit 1 invert |
| cfg_req | input | 1 | Convert period/duty into load/match |
| cfg_period | input | 32 | Requested period in cycles |
| cfg_duty | input | 32 | Requested active time in cycles |
| cfg_err | output | 1 | Last conversion request was rejected |
| stat_run | output | 1 | Timer running |
| stat_inv | output | 1 | Output inversion active |
| pwm_out | output | 1 | PWM output |

## Verification
Every register updates at the edge that captures a write or a conversion request. Status and error values are therefore due one edge after the stimulus. After a start or a polarity-change restart, the output's active edge is due two edges later. The bench drives inputs on falling edges and keeps a behavioural model that advances on each rising edge. It compares all outputs against the model on every falling edge, which is half a cycle after each update. Directed checks add to this comparison. They sample the first three output values after a start or restart, and they measure the full high and low run lengths of a period after each reconfiguration.

// File: rtl/ovf_match_pwm.sv
module ovf_match_pwm #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          cfg_req,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_duty,
  output logic          cfg_err,
  output logic          stat_run,
  output logic          stat_inv,
  output logic          pwm_out
);
  localparam logic [CW-1:0] TOP   = '1;
  localparam logic [CW-1:0] PRIME = TOP - CW'(1);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] TWO   = CW'(2);

  logic [CW-1:0] cnt, load_r, match_r;
  logic          act, run_r, inv_r, err_r;

  logic          per_ok;
  logic [CW-1:0] duty_c, new_load, new_match;
  assign per_ok    = cfg_period >= TWO;
  assign duty_c    = (cfg_duty == '0) ? ONE :
                     (cfg_duty >= cfg_period) ? cfg_period - ONE : cfg_duty;
  assign new_load  = TOP - cfg_period + ONE;
  assign new_match = new_load + duty_c - ONE;

  logic ctrl_wr, restart, halt;
  assign ctrl_wr = wr_en && (wr_sel == 2'd2);
  assign halt    = ctrl_wr && !wr_data[0];
  assign restart = ctrl_wr && wr_data[0] && (!run_r || (wr_data[1] != inv_r));

  always_ff @(posedge clk) begin
    if (rst) begin
      load_r  <= '0;
      match_r <= '0;
      err_r   <= 1'b0;
    end else if (cfg_req) begin
      err_r <= !per_ok;
      if (per_ok) begin
        load_r  <= new_load;
        match_r <= new_match;
      end
    end else if (wr_en && wr_sel == 2'd0) begin
      load_r <= wr_data;
    end else if (wr_en && wr_sel == 2'd1) begin
      match_r <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      act   <= 1'b0;
      run_r <= 1'b0;
      inv_r <= 1'b0;
    end else if (halt) begin
      run_r <= 1'b0;
      inv_r <= wr_data[1];
      act   <= 1'b0;
    end else if (restart) begin
      run_r <= 1'b1;
      inv_r <= wr_data[1];
      cnt   <= PRIME;
      act   <= 1'b0;
    end else if (run_r) begin
      if (cnt == TOP) begin
        cnt <= load_r;
        act <= 1'b1;
      end else begin
        cnt <= cnt + ONE;
        if (cnt == match_r) act <= 1'b0;
      end
    end
  end

  assign cfg_err  = err_r;
  assign stat_run = run_r;
  assign stat_inv = inv_r;
  assign pwm_out  = act ^ inv_r;
endmodule

module ovf_match_pwm_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [CW-1:0] wr_data,
  input logic          cfg_req,
  input logic [CW-1:0] cfg_period,
  input logic          cfg_err,
  input logic          stat_run,
  input logic          stat_inv,
  input logic          pwm_out,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] load_r,
  input logic [CW-1:0] match_r,
  input logic          act
);
  localparam logic [CW-1:0] TOP = '1;

  assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
    (stat_run && cnt == TOP && !(wr_en && wr_sel == 2'd2)) |=> (act && cnt == $past(load_r)));

  assert_match_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (stat_run && cnt == match_r && cnt != TOP && !(wr_en && wr_sel == 2'd2)) |=> !act);

  assert_prime_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2 && wr_data[0] && !stat_run) |=> (stat_run && !act && cnt == TOP - CW'(1)));

  assert_halt_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2 && !wr_data[0]) |=> (!stat_run && $stable(cnt)));

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
    !stat_run |-> (pwm_out == stat_inv));

  assert_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_period < CW'(2)) |=> (cfg_err && $stable(load_r) && $stable(match_r)));

  assert_convert_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_period >= CW'(2)) |=>
      (!cfg_err && CW'(load_r + $past(cfg_period)) == '0 &&
       CW'(match_r - load_r) < CW'($past(cfg_period) - CW'(1))));
endmodule

bind ovf_match_pwm ovf_match_pwm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cfg_req(cfg_req), .cfg_period(cfg_period), .cfg_err(cfg_err),
  .stat_run(stat_run), .stat_inv(stat_inv), .pwm_out(pwm_out),
  .cnt(cnt), .load_r(load_r), .match_r(match_r), .act(act)
);

// File: tb/ovf_match_pwm_tb.sv
module ovf_match_pwm_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        cfg_req = 1'b0;
  logic [31:0] cfg_period = '0;
  logic [31:0] cfg_duty = '0;
  logic        cfg_err, stat_run, stat_inv, pwm_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovf_match_pwm u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg_req(cfg_req), .cfg_period(cfg_period), .cfg_duty(cfg_duty),
    .cfg_err(cfg_err), .stat_run(stat_run), .stat_inv(stat_inv), .pwm_out(pwm_out)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string phase = "R1";

  bit [31:0] m_cnt, m_load, m_match;
  bit        m_act, m_run, m_inv, m_err;

  always @(posedge clk) begin
    bit [31:0] ol, om, d;
    bit        handled;
    ol = m_load; om = m_match; handled = 0;
    if (rst) begin
      m_cnt = 0; m_load = 0; m_match = 0; m_act = 0; m_run = 0; m_inv = 0; m_err = 0;
    end else begin
      if (cfg_req) begin
        if (cfg_period < 2) m_err = 1;
        else begin
          m_err = 0;
          d = cfg_duty;
          if (d == 0) d = 1;
          else if (d >= cfg_period) d = cfg_period - 1;
          m_load  = 32'd0 - cfg_period;
          m_match = m_load + d - 1;
        end
      end else if (wr_en && wr_sel == 0) m_load = wr_data;
      else if (wr_en && wr_sel == 1) m_match = wr_data;
      if (wr_en && wr_sel == 2) begin
        if (!wr_data[0]) begin
          m_run = 0; m_act = 0; m_inv = wr_data[1]; handled = 1;
        end else if (!m_run || wr_data[1] != m_inv) begin
          m_run = 1; m_inv = wr_data[1]; m_cnt = 32'hFFFF_FFFE; m_act = 0; handled = 1;
        end
      end
      if (!handled && m_run) begin
        if (m_cnt == 32'hFFFF_FFFF) begin
          m_cnt = ol; m_act = 1;
        end else begin
          if (m_cnt == om) m_act = 0;
          m_cnt = m_cnt + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    n_vec++;
    if (pwm_out !== (m_act ^ m_inv) || stat_run !== m_run ||
        stat_inv !== m_inv || cfg_err !== m_err) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual out/run/inv/err=%b%b%b%b expected %b%b%b%b",
               phase, cyc, pwm_out, stat_run, stat_inv, cfg_err,
               m_act ^ m_inv, m_run, m_inv, m_err);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL watchdog (R2) actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act_v, input int exp_v);
    n_vec++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cfg(input logic [31:0] per, input logic [31:0] duty);
    cfg_req = 1; cfg_period = per; cfg_duty = duty;
    @(negedge clk);
    cfg_req = 0;
  endtask

  task automatic measure(input string req, input int exp_hi, input int exp_lo);
    int hi = 0;
    int lo = 0;
    int g = 0;
    while (pwm_out !== 1'b0 && g < 300) begin @(negedge clk); g++; end
    while (pwm_out !== 1'b1 && g < 300) begin @(negedge clk); g++; end
    while (pwm_out === 1'b1 && g < 600) begin hi++; @(negedge clk); g++; end
    while (pwm_out === 1'b0 && g < 900) begin lo++; @(negedge clk); g++; end
    check(req, hi, exp_hi);
    check(req, lo, exp_lo);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 0;
    phase = "R1";
    check("R1 out", pwm_out, 0);
    check("R1 run", stat_run, 0);
    check("R1 inv", stat_inv, 0);
    check("R1 err", cfg_err, 0);

    phase = "R9";
    cfg(10, 3);
    check("R9 err clear", cfg_err, 0);
    phase = "R3";
    wr(2, 32'd1);
    check("R3 first sample", pwm_out, 0);
    check("R11 run status", stat_run, 1);
    @(negedge clk);
    check("R3 second sample", pwm_out, 0);
    @(negedge clk);
    check("R3 active edge", pwm_out, 1);
    phase = "R2";
    measure("R2/R9 period 10 duty 3", 3, 7);

    phase = "R8";
    cfg(10, 0);
    measure("R8 duty 0 raised", 1, 9);
    cfg(10, 15);
    measure("R8 duty over period lowered", 9, 1);
    cfg(10, 10);
    measure("R8 duty equal period lowered", 9, 1);

    phase = "R7";
    cfg(1, 1);
    check("R7 err period 1", cfg_err, 1);
    measure("R7 unchanged after period 1", 9, 1);
    cfg(0, 5);
    check("R7 err period 0", cfg_err, 1);
    measure("R7 unchanged after period 0", 9, 1);

    phase = "R10";
    wr(1, 32'hFFFF_FFF6 + 32'd4);
    measure("R10 direct match", 5, 5);
    wr(0, 32'hFFFF_FFF4);
    measure("R10 direct load", 7, 5);

    phase = "R11";
    wr(3, 32'h0);
    measure("R11 sel 3 ignored", 7, 5);
    cfg_req = 1; cfg_period = 10; cfg_duty = 2;
    wr_en = 1; wr_sel = 1; wr_data = 32'hFFFF_FFFE;
    @(negedge clk);
    cfg_req = 0; wr_en = 0;
    measure("R11 conversion wins", 2, 8);

    phase = "R6";
    @(negedge clk);
    wr(2, 32'd3);
    check("R6 inv status", stat_inv, 1);
    check("R6 first sample", pwm_out, 1);
    @(negedge clk);
    check("R6 second sample", pwm_out, 1);
    @(negedge clk);
    check("R6 active edge", pwm_out, 0);

    phase = "R4";
    idle(2);
    wr(2, 32'd2);
    check("R4 stopped", stat_run, 0);
    check("R5 inverted idle high", pwm_out, 1);
    idle(20);
    check("R5 held high", pwm_out, 1);
    phase = "R5";
    wr(2, 32'd0);
    check("R5 idle low", pwm_out, 0);
    check("R11 inv status", stat_inv, 0);

    phase = "R9";
    cfg(2, 1);
    wr(2, 32'd1);
    measure("R9 minimum period", 1, 1);
    cfg(7, 4);
    measure("R9 period 7 duty 4", 4, 3);

    phase = "R1";
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 reset run", stat_run, 0);
    check("R1 reset out", pwm_out, 0);
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule